// File: doc/BRIEF.md
# Sensor Packetizing Interface for a Monitoring Network

This block connects a small group of on-chip sensors to one port of a monitoring-network router. A control sequencer picks one sensor, sends it a one-cycle sample request, waits for that sensor's data-ready strobe, and turns the reading into a single packet. The packet holds the reading, the index of the sensor that produced it, a configurable destination address, and a time stamp. The time stamp comes from a free-running timer, so a consumer can tell how old a reading is. The sensor data lanes are selected through a multiplexer that the sequencer's sensor index drives.

Sensors are sampled in two ways. Periodic sampling is driven by a sample counter and walks through the sensors enabled in a mask, one sensor per period. Event-reported sensors raise a request pulse whenever they have something to report. A per-sensor critical flag, sampled together with the data, steers each packet into one of two small FIFOs: a priority FIFO and a regular FIFO. A single valid/ready output port drains them, and the priority FIFO is always served first. If the target FIFO is full, the sequencer holds the finished packet and starts no new sample until room appears.

Top module: `sensor_pkt_if`

## Requirements
- R1: After reset, `outValid` is 0 and `sampleReq` is all zeros until a sample is triggered.
- R2: With `periodMask` nonzero, a periodic sample starts every PERIOD cycles (default 32). The enabled sensors are visited in rising index order with wrap-around, starting at sensor 0 after reset. Sensors whose mask bit is 0 are never sampled periodically.
- R3: A one-cycle pulse on `eventReq[i]` is remembered until sensor i has been sampled. Pending events are served before a pending periodic sample, the lowest index first.
- R4: A sample request is a single-cycle, one-hot pulse on `sampleReq`. The sequencer then waits for `sensReady` of that same sensor, and a ready strobe from any other sensor is ignored.
- R5: `outData` is 28 bits: destination in [27:22], sensor index in [21:20], time stamp in [19:12], sensor data in [11:0].
- R6: The timer starts at 0 out of reset and rises by 1 each cycle, wrapping at 8 bits. A packet's time stamp is the timer value in the cycle where the ready strobe is accepted, not the value when the packet is sent.
- R7: A reading whose `sensCrit` bit is 1 in its ready cycle goes to the priority FIFO, and `outPri` is 1 while it is presented. All other readings go to the regular FIFO with `outPri` 0.
- R8: When both FIFOs hold packets, the priority packet is presented first.
- R9: When the target FIFO (4 entries) is full, no packet is lost or overwritten. The sequencer issues no new sample request until the packet has been stored. FIFO order is kept.
- R10: While `outValid` is 1 and `outReady` is 0, `outValid` and `outData` hold steady unless a new priority packet is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| destAddr | input | 6 | Destination address placed in every packet |
| periodMask | input | 4 | Sensors enabled for periodic sampling |
| eventReq | input | 4 | Event-report request pulses, one per sensor |
| sampleReq | output | 4 | One-hot sample request to a sensor |
| sensData | input | 48 | Data lanes, 12 bits per sensor, sensor i at [12i+11:12i] |
| sensReady | input | 4 | Data-ready strobes, one per sensor |
| sensCrit | input | 4 | Critical flags, sampled with the data |
| outValid | output | 1 | A packet is presented to the router |
| outReady | input | 1 | Router accepts the presented packet |
| outData | output | 28 | Presented packet |
| outPri | output | 1 | Presented packet is from the priority FIFO |

## Verification
The bench makes the sensor's ready strobe arrive several cycles after the request and predicts the time stamp from its own cycle count. A design that stamped at send time or at request time would put the wrong value in bits [19:12]. A decoy ready strobe from a sensor that was not asked would, if it were accepted, put a wrong index and wrong data in the packet. The bench fills the regular FIFO while the router is stalled, so a design that does not stall would overwrite or drop entries or keep issuing requests. It also queues a regular packet ahead of a critical one, so a design without strict priority would send them in arrival order.

// File: rtl/sensor_pkt_pkg.sv
package sensor_pkt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_WAIT_DATA,
    ST_PACK,
    ST_WAIT_BUF,
    ST_SEND
  } ctrlState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;  // latch reading, time stamp, critical flag, index
    logic build;    // assemble the packet word
    logic push;     // write the packet into its FIFO
  } dpStrobe_t;

endpackage

// File: rtl/sensor_pkt_fifo.sv
module sensor_pkt_fifo #(
  parameter int WIDTH = 28,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             doPush, doPop;

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign dout   = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    if (int'(p) == DEPTH - 1) return '0;
    return p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    push |-> !full) else $error("push into full FIFO"); // R9

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> !empty) else $error("pop from empty FIFO"); // R9

endmodule

// File: rtl/sensor_pkt_ctrl.sv
module sensor_pkt_ctrl
  import sensor_pkt_pkg::*;
#(
  parameter int NUM_SENS = 4,
  parameter int PERIOD   = 32,
  localparam int SEL_W = (NUM_SENS > 1) ? $clog2(NUM_SENS) : 1,
  localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_SENS-1:0] periodMask,
  input  logic [NUM_SENS-1:0] eventReq,
  input  logic [NUM_SENS-1:0] sensReady,
  input  logic                tgtFull,
  output logic [NUM_SENS-1:0] sampleReq,
  output logic [SEL_W-1:0]    selIdx,
  output dpStrobe_t           strobe
);

  ctrlState_t          state, stateNext;
  logic [CNT_W-1:0]    periodCnt;
  logic                periodExpire, periodPend;
  logic [NUM_SENS-1:0] eventPend, eventClr;
  logic [SEL_W-1:0]    lastPer;
  logic [SEL_W-1:0]    evIdx, perIdx;
  logic                evFound, perFound;
  logic                takeEv, takePer;

  // Sample counter: expires once every PERIOD cycles
  assign periodExpire = (periodCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) periodCnt <= CNT_W'(PERIOD - 1);
    else if (periodExpire) periodCnt <= CNT_W'(PERIOD - 1);
    else periodCnt <= periodCnt - CNT_W'(1);
  end

  // Lowest pending event, and next mask-enabled sensor after the last periodic one
  always_comb begin
    evFound = 1'b0;
    evIdx   = '0;
    for (int i = NUM_SENS - 1; i >= 0; i--) begin
      if (eventPend[i]) begin
        evFound = 1'b1;
        evIdx   = SEL_W'(i);
      end
    end
    perFound = 1'b0;
    perIdx   = '0;
    for (int k = NUM_SENS; k >= 1; k--) begin
      int cand;
      cand = (int'(lastPer) + k) % NUM_SENS;
      if (periodMask[cand]) begin
        perFound = 1'b1;
        perIdx   = SEL_W'(cand);
      end
    end
  end

  assign takeEv   = (state == ST_IDLE) && evFound;
  assign takePer  = (state == ST_IDLE) && !evFound && periodPend && perFound;
  assign eventClr = takeEv ? (NUM_SENS'(1) << evIdx) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eventPend  <= '0;
      periodPend <= 1'b0;
      lastPer    <= SEL_W'(NUM_SENS - 1);
      selIdx     <= '0;
    end else begin
      eventPend  <= (eventPend | eventReq) & ~eventClr;
      periodPend <= (periodPend && !takePer && (|periodMask)) ||
                    (periodExpire && (|periodMask));
      if (takeEv) begin
        selIdx <= evIdx;
      end else if (takePer) begin
        selIdx  <= perIdx;
        lastPer <= perIdx;
      end
    end
  end

  // Sequencer
  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE:      if (takeEv || takePer) stateNext = ST_SAMPLE;
      ST_SAMPLE:    stateNext = ST_WAIT_DATA;
      ST_WAIT_DATA: if (sensReady[selIdx]) begin
                      strobe.capture = 1'b1;
                      stateNext      = ST_PACK;
                    end
      ST_PACK:      begin
                      strobe.build = 1'b1;
                      stateNext    = tgtFull ? ST_WAIT_BUF : ST_SEND;
                    end
      ST_WAIT_BUF:  if (!tgtFull) stateNext = ST_SEND;
      ST_SEND:      begin
                      strobe.push = 1'b1;
                      stateNext   = ST_IDLE;
                    end
      default:      stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else state <= stateNext;
  end

  assign sampleReq = (state == ST_SAMPLE) ? (NUM_SENS'(1) << selIdx) : '0;

  AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (sampleReq != '0) |=> (sampleReq == '0)) else $error("request longer than one cycle"); // R4

endmodule

// File: rtl/sensor_pkt_dp.sv
module sensor_pkt_dp
  import sensor_pkt_pkg::*;
#(
  parameter int NUM_SENS   = 4,
  parameter int DATA_W     = 12,
  parameter int DEST_W     = 6,
  parameter int TS_W       = 8,
  parameter int FIFO_DEPTH = 4,
  localparam int SEL_W = (NUM_SENS > 1) ? $clog2(NUM_SENS) : 1,
  localparam int PKT_W = DEST_W + SEL_W + TS_W + DATA_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpStrobe_t                  strobe,
  input  logic [SEL_W-1:0]           selIdx,
  input  logic [NUM_SENS*DATA_W-1:0] sensData,
  input  logic [NUM_SENS-1:0]        sensCrit,
  input  logic [DEST_W-1:0]          destAddr,
  input  logic                       outReady,
  output logic                       tgtFull,
  output logic                       outValid,
  output logic [PKT_W-1:0]           outData,
  output logic                       outPri
);

  localparam int NUM_CH = 2;  // channel 0 regular, channel 1 priority

  logic [TS_W-1:0]   timer;
  logic [DATA_W-1:0] dataQ;
  logic [TS_W-1:0]   tsQ;
  logic [SEL_W-1:0]  idxQ;
  logic              critQ, critPkt;
  logic [PKT_W-1:0]  pktQ;

  logic [NUM_CH-1:0] chFull, chEmpty, chPush, chPop;
  logic [PKT_W-1:0]  chDout [NUM_CH];
  logic              usePri;

  // Free-running time-stamp timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timer <= '0;
    else timer <= timer + TS_W'(1);
  end

  // Capture and packetization registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ   <= '0;
      tsQ     <= '0;
      idxQ    <= '0;
      critQ   <= 1'b0;
      pktQ    <= '0;
      critPkt <= 1'b0;
    end else begin
      if (strobe.capture) begin
        dataQ <= sensData[int'(selIdx)*DATA_W +: DATA_W];
        tsQ   <= timer;
        idxQ  <= selIdx;
        critQ <= sensCrit[selIdx];
      end
      if (strobe.build) begin
        pktQ    <= {destAddr, idxQ, tsQ, dataQ};
        critPkt <= critQ;
      end
    end
  end

  assign tgtFull = critQ ? chFull[1] : chFull[0];

  // Strict priority selection toward the router port
  assign usePri   = !chEmpty[1];
  assign outValid = !chEmpty[1] || !chEmpty[0];
  assign outPri   = usePri;
  assign outData  = usePri ? chDout[1] : chDout[0];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gCh
    assign chPush[ch] = strobe.push && (critPkt == (ch == 1));
    assign chPop[ch]  = outValid && outReady && (usePri == (ch == 1));

    sensor_pkt_fifo #(
      .WIDTH(PKT_W),
      .DEPTH(FIFO_DEPTH)
    ) uFifo (
      .clk   (clk),
      .rstN  (rstN),
      .push  (chPush[ch]),
      .din   (pktQ),
      .pop   (chPop[ch]),
      .dout  (chDout[ch]),
      .full  (chFull[ch]),
      .empty (chEmpty[ch])
    );
  end

  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> timer == $past(timer) + TS_W'(1)) else $error("timer skipped"); // R6

  AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> !tgtFull) else $error("packet stored into full FIFO"); // R9

  AST_PRI_VISIBLE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && critPkt) |=> (outValid && outPri)) else $error("priority packet not presented"); // R7

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !(strobe.push && critPkt)) |=> (outValid && $stable(outData)))
    else $error("presented packet changed while stalled"); // R10

endmodule

// File: rtl/sensor_pkt_if.sv
module sensor_pkt_if
  import sensor_pkt_pkg::*;
#(
  parameter int NUM_SENS   = 4,
  parameter int DATA_W     = 12,
  parameter int DEST_W     = 6,
  parameter int TS_W       = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int PERIOD     = 32,
  localparam int SEL_W = (NUM_SENS > 1) ? $clog2(NUM_SENS) : 1,
  localparam int PKT_W = DEST_W + SEL_W + TS_W + DATA_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [DEST_W-1:0]          destAddr,
  input  logic [NUM_SENS-1:0]        periodMask,
  input  logic [NUM_SENS-1:0]        eventReq,
  output logic [NUM_SENS-1:0]        sampleReq,
  input  logic [NUM_SENS*DATA_W-1:0] sensData,
  input  logic [NUM_SENS-1:0]        sensReady,
  input  logic [NUM_SENS-1:0]        sensCrit,
  output logic                       outValid,
  input  logic                       outReady,
  output logic [PKT_W-1:0]           outData,
  output logic                       outPri
);

  dpStrobe_t        strobe;
  logic [SEL_W-1:0] selIdx;
  logic             tgtFull;

  sensor_pkt_ctrl #(
    .NUM_SENS(NUM_SENS),
    .PERIOD  (PERIOD)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .periodMask (periodMask),
    .eventReq   (eventReq),
    .sensReady  (sensReady),
    .tgtFull    (tgtFull),
    .sampleReq  (sampleReq),
    .selIdx     (selIdx),
    .strobe     (strobe)
  );

  sensor_pkt_dp #(
    .NUM_SENS  (NUM_SENS),
    .DATA_W    (DATA_W),
    .DEST_W    (DEST_W),
    .TS_W      (TS_W),
    .FIFO_DEPTH(FIFO_DEPTH)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .selIdx   (selIdx),
    .sensData (sensData),
    .sensCrit (sensCrit),
    .destAddr (destAddr),
    .outReady (outReady),
    .tgtFull  (tgtFull),
    .outValid (outValid),
    .outData  (outData),
    .outPri   (outPri)
  );

endmodule

// File: tb/sim_sensor_pkt_if.sv
module sim_sensor_pkt_if;

  localparam int NS   = 4;
  localparam int DW   = 12;
  localparam int PW   = 28;
  localparam int PER  = 32;
  localparam logic [5:0] DEST = 6'h2A;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [5:0]    destAddr = DEST;
  logic [NS-1:0] periodMask = '0;
  logic [NS-1:0] eventReq = '0;
  logic [NS-1:0] sampleReq;
  logic [NS*DW-1:0] sensData = '0;
  logic [NS-1:0] sensReady = '0;
  logic [NS-1:0] sensCrit = '0;
  logic          outValid;
  logic          outReady = 1'b0;
  logic [PW-1:0] outData;
  logic          outPri;

  always #5 clk = ~clk;

  sensor_pkt_if u0 (
    .clk(clk), .rstN(rstN), .destAddr(destAddr), .periodMask(periodMask),
    .eventReq(eventReq), .sampleReq(sampleReq), .sensData(sensData),
    .sensReady(sensReady), .sensCrit(sensCrit), .outValid(outValid),
    .outReady(outReady), .outData(outData), .outPri(outPri)
  );

  // Bench counters (one writer each)
  int checks = 0, errors = 0;      // tasks
  int ckChecks = 0, ckErrors = 0;  // packet checker
  bit done = 1'b0;

  // Reference cycle count: mirrors the time-stamp timer (R6)
  int tbTime = 0;
  always @(posedge clk) if (rstN) tbTime <= tbTime + 1;

  // Sensor model with request log
  int  respIdx = 0, respWait = 0, seq = 1;
  int  respLat = 2;
  bit  decoyEn = 1'b0;
  bit  critTab [NS];
  int  reqCount = 0;
  int  reqIdxLog [$];
  int  reqTimeLog [$];
  logic [PW-1:0] expReg [$];
  logic [PW-1:0] expPri [$];
  bit  popPri [$];

  initial for (int i = 0; i < NS; i++) critTab[i] = 1'b0;

  always @(negedge clk) begin
    sensReady = '0;
    sensCrit  = '0;
    if (respWait > 0) begin
      respWait = respWait - 1;
      if (respWait == 1 && decoyEn) begin
        int o;
        o = (respIdx + 1) % NS;
        sensReady[o] = 1'b1;
        sensData[o*DW +: DW] = 12'hBAD;
      end else if (respWait == 0) begin
        logic [DW-1:0] dat;
        logic [PW-1:0] pkt;
        dat = {respIdx[1:0], 2'b00, seq[7:0]};
        sensData[respIdx*DW +: DW] = dat;
        sensReady[respIdx] = 1'b1;
        sensCrit[respIdx]  = critTab[respIdx];
        pkt = {DEST, respIdx[1:0], tbTime[7:0], dat};  // R5 layout, R6 stamp
        if (critTab[respIdx]) expPri.push_back(pkt);
        else expReg.push_back(pkt);
        seq = seq + 1;
      end
    end else if (sampleReq != '0) begin
      for (int i = 0; i < NS; i++) if (sampleReq[i]) respIdx = i;
      respWait = respLat;
    end
    if (sampleReq != '0) begin
      for (int i = 0; i < NS; i++) if (sampleReq[i]) reqIdxLog.push_back(i);
      reqTimeLog.push_back(tbTime);
      reqCount = reqCount + 1;
    end
  end

  // Packet checker on every accepted transfer (R5, R6, R7)
  always @(negedge clk) begin
    if (rstN && outValid && outReady) begin
      logic [PW-1:0] exp;
      ckChecks = ckChecks + 1;
      popPri.push_back(outPri);
      if (outPri ? (expPri.size() == 0) : (expReg.size() == 0)) begin
        ckErrors = ckErrors + 1;
        $display("FAIL R7: unexpected packet %h on pri=%0d", outData, outPri);
      end else begin
        exp = outPri ? expPri.pop_front() : expReg.pop_front();
        if (outData !== exp) begin
          ckErrors = ckErrors + 1;
          $display("FAIL R5/R6: packet %h expected %h (pri=%0d)", outData, exp, outPri);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitReqs(input int target, input int limit);
    int n = 0;
    while (reqCount < target && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pulseEvent(input logic [NS-1:0] m);
    @(negedge clk);
    eventReq = m;
    @(negedge clk);
    eventReq = '0;
  endtask

  task automatic testReset();
    chk(outValid == 1'b0, "R1 outValid in reset", outValid, 0);
    chk(sampleReq == '0, "R1 sampleReq in reset", sampleReq, 0);
    @(negedge clk);
    rstN = 1'b1;
    cycles(40);
    chk(outValid == 1'b0, "R1 outValid idle", outValid, 0);
    chk(reqCount == 0, "R1 no request with nothing enabled", reqCount, 0);
  endtask

  task automatic testPeriodic();
    int base;
    base = reqCount;
    outReady   = 1'b1;
    periodMask = 4'b0101;
    waitReqs(base + 3, 200);
    periodMask = '0;
    chk(reqCount >= base + 3, "R2 periodic requests seen", reqCount - base, 3);
    if (reqCount >= base + 3) begin
      chk(reqIdxLog[base] == 0, "R2 first periodic sensor", reqIdxLog[base], 0);
      chk(reqIdxLog[base+1] == 2, "R2 second periodic sensor", reqIdxLog[base+1], 2);
      chk(reqIdxLog[base+2] == 0, "R2 third periodic sensor", reqIdxLog[base+2], 0);
      chk(reqTimeLog[base+1] - reqTimeLog[base] == PER, "R2 period spacing",
          reqTimeLog[base+1] - reqTimeLog[base], PER);
      chk(reqTimeLog[base+2] - reqTimeLog[base+1] == PER, "R2 period spacing",
          reqTimeLog[base+2] - reqTimeLog[base+1], PER);
    end
    cycles(80);
    chk(expReg.size() == 0, "R6 periodic packets delivered", expReg.size(), 0);
  endtask

  task automatic testEvents();
    int base;
    base    = reqCount;
    decoyEn = 1'b1;  // R4: a wrong sensor strobes ready first
    respLat = 2;
    pulseEvent(4'b1010);
    waitReqs(base + 2, 100);
    cycles(20);
    decoyEn = 1'b0;
    chk(reqCount == base + 2, "R3 two event samples", reqCount - base, 2);
    if (reqCount >= base + 2) begin
      chk(reqIdxLog[base] == 1, "R3 lowest event first", reqIdxLog[base], 1);
      chk(reqIdxLog[base+1] == 3, "R3 second event", reqIdxLog[base+1], 3);
    end
    // R6: long sensor latency, stamp must follow the ready cycle
    respLat = 7;
    pulseEvent(4'b0001);
    cycles(30);
    respLat = 2;
    chk(expReg.size() == 0, "R4/R6 event packets delivered", expReg.size(), 0);
  endtask

  task automatic testPriority();
    int p0;
    outReady   = 1'b0;
    critTab[2] = 1'b1;
    pulseEvent(4'b0010);
    cycles(12);
    chk(outValid && !outPri, "R7 regular packet presented", {outValid, outPri}, 2'b10);
    pulseEvent(4'b0100);
    cycles(12);
    chk(outValid && outPri, "R7 critical packet on priority", {outValid, outPri}, 2'b11);
    chk(outData[21:20] == 2'd2, "R8 priority packet presented first", outData[21:20], 2);
    p0 = popPri.size();
    outReady = 1'b1;
    cycles(6);
    chk(popPri.size() == p0 + 2, "R8 both packets drained", popPri.size() - p0, 2);
    if (popPri.size() >= p0 + 2) begin
      chk(popPri[p0] == 1'b1, "R8 priority popped first", popPri[p0], 1);
      chk(popPri[p0+1] == 1'b0, "R8 regular popped second", popPri[p0+1], 0);
    end
    critTab[2] = 1'b0;
  endtask

  task automatic testFull();
    int base, p0;
    logic [PW-1:0] held;
    outReady = 1'b0;
    p0 = popPri.size();
    for (int k = 0; k < 5; k++) begin
      pulseEvent(4'b1000);
      cycles(10);
    end
    base = reqCount;
    held = outData;
    pulseEvent(4'b0001);
    cycles(15);
    chk(reqCount == base, "R9 no request while buffer full", reqCount - base, 0);
    chk(outValid == 1'b1, "R10 valid held while stalled", outValid, 1);
    chk(outData == held, "R10 data held while stalled", outData, held);
    chk(expReg.size() == 5, "R9 five readings captured", expReg.size(), 5);
    outReady = 1'b1;
    cycles(40);
    chk(popPri.size() - p0 == 6, "R9 no packet lost", popPri.size() - p0, 6);
    chk(expReg.size() == 0, "R9 all regular packets delivered in order", expReg.size(), 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors = errors + 1;
      $display("FAIL R1-watchdog: run did not finish, got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors",
               checks + ckChecks + 1, errors + ckErrors);
      $finish;
    end
  end

  initial begin
    cycles(3);
    testReset();
    testPeriodic();
    testEvents();
    testPriority();
    testFull();
    chk(expPri.size() == 0, "R7 no priority packet left", expPri.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors",
             checks + ckChecks, errors + ckErrors);
    $finish;
  end

endmodule